// File: doc/BRIEF.md
# Timed Window Temporal Observer

This block watches a design at run time and checks one bounded-delay relation between a reference point and a target. A mode input picks the relation. In precede mode the reference is the end of an activation state, and the target is the start of a second state. In trigger mode the reference is an event strobe, and the target is the start of a state. In terminate mode the reference is an event that arrives while the activation state holds, and the target is the end of that same state. The caller supplies the state flags and the event strobe. The observer does not derive them from design signals.

Delay is counted in ticks of a separate logical time base, `tick_i`, and not in system clock cycles. The window bounds are `min_i` and `max_i`. A zero upper bound means the window has no upper limit and a zero lower bound means it has no lower limit. So `[0,n]` reads as "by tick n", `[m,0]` reads as "at tick m or later" and `[m,m]` reads as "at exactly tick m". When a check ends, the observer reports the outcome as a single-cycle `viol_o` pulse and then stays dormant until the next reference.

Top module: `twin_observer`

## Requirements
- R1: `rst` is synchronous and active high. In the cycle after a reset cycle `viol_o` is 0 and no check is pending, so ticks and targets that follow produce no violation until a new reference arrives.
- R2: With `mode_i` = 0 (precede), the reference is a cycle in which `act_i` is 0 after being 1 in the previous cycle. The target is a cycle in which `tgt_i` is 1 after being 0.
- R3: With `mode_i` = 1 (trigger), the reference is any cycle with `evt_i` = 1. The target is a 0-to-1 change of `tgt_i`.
- R4: With `mode_i` = 2 (terminate), the reference is a cycle with `evt_i` = 1 and `act_i` = 1. An `evt_i` pulse while `act_i` is 0 is ignored. The target is a 1-to-0 change of `act_i`.
- R5: After a reference, each later cycle with `tick_i` = 1 adds one to the count. A tick in the cycle of the target is included when that target is judged. A tick in the reference cycle is not counted.
- R6: A target passes when count >= `min_i` and either `max_i` = 0 or count <= `max_i`. A passing target produces no violation.
- R7: A target whose count is below `min_i` produces a violation.
- R8: While a check is pending and `max_i` is nonzero, a tick that raises the count to `max_i`+1 without a target in that cycle produces a violation.
- R9: `viol_o` is registered. It is 1 for exactly the one cycle after the cycle in which the failing decision was made, and it is 0 in the following cycle unless a new decision fails.
- R10: After a check ends, whether it passed or failed, targets and ticks cause no violation until the next reference.
- R11: A reference that arrives while a check is pending discards the old count and starts a new check from zero.
- R12: A target in the same cycle as its reference is judged with a count of zero. It produces a violation exactly when `min_i` is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Relation select: 0 precede, 1 trigger, 2 terminate, 3 off |
| act_i | input | 1 | Activation state flag |
| evt_i | input | 1 | Trigger event strobe |
| tgt_i | input | 1 | Target state flag (precede and trigger modes) |
| tick_i | input | 1 | Logical time base strobe that advances the delay count |
| min_i | input | CNT_W | Lower window bound in ticks, 0 = no lower limit |
| max_i | input | CNT_W | Upper window bound in ticks, 0 = no upper limit |
| viol_o | output | 1 | One-cycle violation pulse |

## Verification
Every decision (an early target, a late tick, or a zero-count judgement in the reference cycle) is taken from the inputs that are present just before a rising clock edge. The result shows on `viol_o` right after that same edge, one register stage later. The driver changes inputs on the falling edge. For each cycle it queues the `viol_o` value expected after the next rising edge, and the monitor takes that value off the queue shortly after the rising edge, so each sample lines up with exactly one decision cycle. The stimulus places ticks so that a missed restart or a counted ignored event would cause a timeout in a cycle where the queue expects 0.

// File: rtl/twin_pkg.sv
package twin_pkg;
   typedef enum logic [1:0] {
      TW_PRECEDE   = 2'd0,
      TW_TRIGGER   = 2'd1,
      TW_TERMINATE = 2'd2,
      TW_OFF       = 2'd3
   } tw_mode_e;
endpackage

// File: rtl/tw_edge.sv
module tw_edge #(
   parameter bit RISE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic sig_i,
   output logic edge_o
);
   logic sig_q;

   always_ff @(posedge clk) begin
      if (rst) sig_q <= 1'b0;
      else     sig_q <= sig_i;
   end

   generate
      if (RISE) begin : g_rise
         assign edge_o = sig_i & ~sig_q;
      end else begin : g_fall
         assign edge_o = ~sig_i & sig_q;
      end
   endgenerate

   // R2: a detected edge means the level really changed since last cycle
   p_edge_change_r2: assert property (@(posedge clk) disable iff (rst)
      edge_o |=> $past(sig_i) != $past(sig_q));
endmodule

// File: rtl/tw_tick_cnt.sv
module tw_tick_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] CNT_TOP = {W{1'b1}};

   generate
      if (W < 2) begin : g_bad_w
         initial $fatal(1, "tw_tick_cnt: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clr_i)                  cnt_o <= '0;
      else if (inc_i && cnt_o != CNT_TOP) cnt_o <= cnt_o + 1'b1;
   end

   // R11: a restart leaves the count at zero
   p_clear_zero_r11: assert property (@(posedge clk) disable iff (rst)
      clr_i |=> cnt_o == '0);
   // R5: the count saturates rather than wrapping
   p_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
      (cnt_o == CNT_TOP && !clr_i) |=> cnt_o == CNT_TOP);
endmodule

// File: rtl/tw_window.sv
module tw_window #(
   parameter int W         = 8,
   parameter bit ZERO_OPEN = 1'b1
) (
   input  logic [W-1:0] cnt_i,
   input  logic         tick_i,
   input  logic [W-1:0] min_i,
   input  logic [W-1:0] max_i,
   output logic         pass_o,
   output logic         late_o
);
   localparam int EW = W + 1;

   logic [EW-1:0] eff;
   logic          lo_ok;
   logic          hi_ok;
   logic          over;

   assign eff   = EW'(cnt_i) + EW'(tick_i);
   assign lo_ok = eff >= EW'(min_i);
   assign over  = eff > EW'(max_i);

   generate
      if (ZERO_OPEN) begin : g_zero_open
         assign hi_ok  = (max_i == '0) | ~over;
         assign late_o = tick_i & (max_i != '0) & over;
      end else begin : g_zero_closed
         assign hi_ok  = ~over;
         assign late_o = tick_i & over;
      end
   endgenerate

   assign pass_o = lo_ok & hi_ok;
endmodule

// File: rtl/twin_observer.sv
module twin_observer
   import twin_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       mode_i,
   input  logic             act_i,
   input  logic             evt_i,
   input  logic             tgt_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] min_i,
   input  logic [CNT_W-1:0] max_i,
   output logic             viol_o
);
   localparam int EW = CNT_W + 1;

   generate
      if (CNT_W < 2 || CNT_W > 30) begin : g_bad_cnt
         initial $fatal(1, "twin_observer: CNT_W out of range");
      end
   endgenerate

   tw_mode_e         mode;
   logic             act_fall;
   logic             tgt_rise;
   logic             ref_ev;
   logic             tgt_ev;
   logic             busy_q, busy_d;
   logic             viol_d;
   logic [CNT_W-1:0] cnt_q;
   logic             pass;
   logic             late;

   assign mode = tw_mode_e'(mode_i);

   tw_edge #(.RISE(1'b0)) u_act_edge (
      .clk(clk), .rst(rst), .sig_i(act_i), .edge_o(act_fall));
   tw_edge #(.RISE(1'b1)) u_tgt_edge (
      .clk(clk), .rst(rst), .sig_i(tgt_i), .edge_o(tgt_rise));

   always_comb begin
      ref_ev = 1'b0;
      tgt_ev = 1'b0;
      case (mode)
         TW_PRECEDE:   begin ref_ev = act_fall;        tgt_ev = tgt_rise; end
         TW_TRIGGER:   begin ref_ev = evt_i;           tgt_ev = tgt_rise; end
         TW_TERMINATE: begin ref_ev = evt_i & act_i;   tgt_ev = act_fall; end
         default:      begin ref_ev = 1'b0;            tgt_ev = 1'b0;     end
      endcase
   end

   tw_tick_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .clr_i(ref_ev),
      .inc_i(busy_q & tick_i), .cnt_o(cnt_q));

   tw_window #(.W(CNT_W), .ZERO_OPEN(1'b1)) u_win (
      .cnt_i(cnt_q), .tick_i(tick_i), .min_i(min_i), .max_i(max_i),
      .pass_o(pass), .late_o(late));

   always_comb begin
      busy_d = busy_q;
      viol_d = 1'b0;
      if (ref_ev) begin
         if (tgt_ev) begin
            busy_d = 1'b0;
            viol_d = (min_i != '0);
         end else begin
            busy_d = 1'b1;
         end
      end else if (busy_q) begin
         if (tgt_ev) begin
            busy_d = 1'b0;
            viol_d = ~pass;
         end else if (late) begin
            busy_d = 1'b0;
            viol_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         viol_o <= 1'b0;
      end else begin
         busy_q <= busy_d;
         viol_o <= viol_d;
      end
   end

   // R1: reset leaves no violation behind
   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |=> !viol_o);
   // R10: no pending check and no reference means no violation
   p_dormant_r10: assert property (@(posedge clk) disable iff (rst)
      (!busy_q && !ref_ev) |=> !viol_o);
   // R11: a reference without a same-cycle target opens a fresh check
   p_restart_r11: assert property (@(posedge clk) disable iff (rst)
      (ref_ev && !tgt_ev) |=> (busy_q && cnt_q == '0));
   // R8: the tick past the upper bound flags a violation
   p_late_r8: assert property (@(posedge clk) disable iff (rst)
      (busy_q && !ref_ev && !tgt_ev && tick_i && max_i != '0 && cnt_q == max_i)
      |=> viol_o);
   // R7: a target below the lower bound flags a violation
   p_early_r7: assert property (@(posedge clk) disable iff (rst)
      (busy_q && !ref_ev && tgt_ev && (EW'(cnt_q) + EW'(tick_i) < EW'(min_i)))
      |=> viol_o);
   // R12: a same-cycle target with zero lower bound passes
   p_zero_pass_r12: assert property (@(posedge clk) disable iff (rst)
      (ref_ev && tgt_ev && min_i == '0) |=> !viol_o);
endmodule

// File: tb/twin_observer_tb_top.sv
module twin_observer_tb_top;
   localparam int CLK_P = 10;
   localparam int W     = 8;

   typedef struct {
      logic  v;
      string tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [1:0]   mode = 2'd0;
   logic         act = 1'b0, evt = 1'b0, tgt = 1'b0, tick = 1'b0;
   logic [W-1:0] min_w = '0, max_w = '0;
   logic         viol;

   int   total = 0;
   int   bad   = 0;
   bit   done  = 1'b0;
   exp_t q[$];

   always #(CLK_P/2) clk = ~clk;

   twin_observer #(.CNT_W(W)) dut_i (
      .clk(clk), .rst(rst), .mode_i(mode), .act_i(act), .evt_i(evt),
      .tgt_i(tgt), .tick_i(tick), .min_i(min_w), .max_i(max_w), .viol_o(viol));

   // monitor: compares one queued expectation per rising edge
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         total++;
         if (viol !== e.v) begin
            bad++;
            $display("FAIL %s: viol_o=%b expected %b at %0t", e.tag, viol, e.v, $time);
         end
      end
   end

   task automatic step(input logic a, input logic e, input logic t,
                       input logic k, input logic ex, input string tag);
      exp_t it;
      @(negedge clk);
      act = a; evt = e; tgt = t; tick = k;
      it.v = ex; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic quiet(input int n, input string tag);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
   endtask

   initial begin
      step(0, 0, 0, 0, 0, "R1");
      step(0, 0, 0, 0, 0, "R1");
      rst = 1'b0;

      // precede mode, window [2,3]
      mode = 2'd0; min_w = 8'd2; max_w = 8'd3;
      step(1, 0, 0, 0, 0, "R2"); step(0, 0, 0, 0, 0, "R2");
      step(0, 0, 0, 1, 0, "R2"); step(0, 0, 0, 1, 0, "R2");
      step(0, 0, 1, 0, 0, "R2");
      step(0, 0, 0, 0, 0, "R10");
      // early target
      step(1, 0, 0, 0, 0, "R7"); step(0, 0, 0, 0, 0, "R7");
      step(0, 0, 0, 1, 0, "R7");
      step(0, 0, 1, 0, 1, "R7");
      step(0, 0, 0, 0, 0, "R9");
      step(0, 0, 1, 0, 0, "R10");
      quiet(1, "R10");
      // late: fourth tick exceeds 3
      step(1, 0, 0, 0, 0, "R8"); step(0, 0, 0, 0, 0, "R8");
      step(0, 0, 0, 1, 0, "R8"); step(0, 0, 0, 1, 0, "R8"); step(0, 0, 0, 1, 0, "R8");
      step(0, 0, 0, 1, 1, "R8");
      step(0, 0, 0, 1, 0, "R9");
      step(0, 0, 1, 0, 0, "R10");
      quiet(1, "R10");
      // tick in reference cycle is not counted
      step(1, 0, 0, 0, 0, "R5"); step(0, 0, 0, 1, 0, "R5");
      step(0, 0, 0, 1, 0, "R5");
      step(0, 0, 1, 0, 1, "R5");
      quiet(1, "R5");
      // tick coinciding with target counts
      step(1, 0, 0, 0, 0, "R5"); step(0, 0, 0, 0, 0, "R5");
      step(0, 0, 0, 1, 0, "R5");
      step(0, 0, 1, 1, 0, "R5");
      quiet(1, "R5");
      // restart while pending
      step(1, 0, 0, 0, 0, "R11"); step(0, 0, 0, 0, 0, "R11");
      step(0, 0, 0, 1, 0, "R11"); step(0, 0, 0, 1, 0, "R11");
      step(1, 0, 0, 0, 0, "R11"); step(0, 0, 0, 0, 0, "R11");
      step(0, 0, 0, 1, 0, "R11"); step(0, 0, 0, 1, 0, "R11");
      step(0, 0, 1, 0, 0, "R11");
      quiet(1, "R11");
      // same-cycle target
      step(1, 0, 0, 0, 0, "R12"); step(0, 0, 1, 0, 1, "R12");
      quiet(1, "R12");
      min_w = 8'd0;
      step(1, 0, 0, 0, 0, "R12"); step(0, 0, 1, 0, 0, "R12");
      step(0, 0, 0, 1, 0, "R10"); step(0, 0, 0, 1, 0, "R10");
      // unbounded upper limit [1,0]
      min_w = 8'd1; max_w = 8'd0;
      step(1, 0, 0, 0, 0, "R6"); step(0, 0, 0, 0, 0, "R6");
      for (int i = 0; i < 20; i++) step(0, 0, 0, 1, 0, "R6");
      step(0, 0, 1, 0, 0, "R6");
      quiet(1, "R6");
      // no lower limit [0,2]
      min_w = 8'd0; max_w = 8'd2;
      step(1, 0, 0, 0, 0, "R6"); step(0, 0, 0, 0, 0, "R6");
      step(0, 0, 1, 0, 0, "R6");
      quiet(1, "R6");

      // trigger mode, window [1,2]
      mode = 2'd1; min_w = 8'd1; max_w = 8'd2;
      step(0, 1, 0, 0, 0, "R3"); step(0, 0, 0, 1, 0, "R3");
      step(0, 0, 1, 0, 0, "R3");
      quiet(1, "R3");
      step(0, 1, 0, 0, 0, "R3"); step(0, 0, 0, 1, 0, "R3"); step(0, 0, 0, 1, 0, "R3");
      step(0, 0, 0, 1, 1, "R3");
      quiet(1, "R3");
      step(0, 1, 0, 0, 0, "R3");
      step(0, 0, 1, 0, 1, "R3");
      quiet(1, "R3");

      // terminate mode, window [1,2]
      mode = 2'd2;
      step(1, 0, 0, 0, 0, "R4"); step(1, 1, 0, 0, 0, "R4");
      step(1, 0, 0, 1, 0, "R4");
      step(0, 0, 0, 0, 0, "R4");
      step(0, 1, 0, 0, 0, "R4");
      step(1, 0, 0, 1, 0, "R4"); step(1, 0, 0, 1, 0, "R4");
      step(1, 0, 0, 1, 0, "R4"); step(1, 0, 0, 1, 0, "R4");
      step(0, 0, 0, 0, 0, "R4");
      step(1, 0, 0, 0, 0, "R4"); step(1, 1, 0, 0, 0, "R4");
      step(0, 0, 0, 0, 1, "R4");
      quiet(1, "R4");

      // reset while pending
      mode = 2'd0; min_w = 8'd2; max_w = 8'd3;
      step(1, 0, 0, 0, 0, "R1"); step(0, 0, 0, 0, 0, "R1");
      step(0, 0, 0, 1, 0, "R1");
      rst = 1'b1;
      step(0, 0, 0, 0, 0, "R1");
      rst = 1'b0;
      for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, "R1");
      step(0, 0, 1, 0, 0, "R1");
      quiet(2, "R1");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: run hung, actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule